// File: doc/BRIEF.md
# Dual-Bank Edge/Level Interrupt Controller

This block gathers 64 interrupt inputs, arranged as a low and a high half of 32 lines each, and folds them into one interrupt output towards a processor. Every line can be told to react to a rising edge, a falling edge, a high level or a low level. The trigger is set by two independent configuration bits per line, one for rise and one for fall. Edges are caught in a latch that stays set until software acknowledges it.

Software works through a simple register bus: a write strobe with address and data, and a read port that is decoded combinationally from the address. For each half there is an enable mask and a software-force mask. Both are changed only through write-one-to-set and write-one-to-clear aliases. Masked (status) and unmasked (raw) views can be read back. A separate edge group holds the rise and fall configuration, which can be written directly or through set and clear aliases. The same group holds the edge latches, and writing ones to its raw view acknowledges them.

The output is asserted whenever any enabled line of either half is active. Picking which line to serve is left to software.

Top module: `ictl_dual_bank`

## Requirements
- R1: After reset every readable register reads 0, including enable, force, rise and fall configuration and the edge latches. The output is low, and every line is in level-high mode.
- R2: Writing to enable-set (half base + 0x08) sets only the bits written as 1, and writing to enable-clear (+0x0c) clears only those bits. Both addresses read back the enable mask.
- R3: Writing to force-set (+0x10) sets only the bits written as 1, and writing to force-clear (+0x14) clears only those bits. Both addresses read back the force mask.
- R4: The pair {rise bit, fall bit} selects the trigger per line: 10 is rising edge, 01 is falling edge, 00 is level high and 11 is level low.
- R5: Rise configuration is written directly at edge base + 0x08, and fall configuration at + 0x0c. The set aliases (+0x10 rise, +0x18 fall) and clear aliases (+0x14 rise, +0x1c fall) change only the bits written as 1. All of these addresses read back the matching configuration.
- R6: In an edge mode, the selected transition of a line sets its edge latch. In level modes no latch is set. Edge raw (+0x04) reads the latches. Edge status (+0x00) reads the latches of lines that are in an edge mode.
- R7: Writing 1s to edge raw clears those latches and leaves all other latches unchanged.
- R8: Bank status (+0x00) equals (conditioned input OR force) AND enable, and bank raw (+0x04) equals conditioned input OR force. The conditioned input is the latch in edge modes, the input itself in level high, and the inverted input in level low.
- R9: The output is high exactly when some bit of either half's bank status is 1. It follows the status one clock later.
- R10: Bank registers sit at base 0x000 for the low half and 0x018 for the high half. Edge registers sit at 0x200 for the low half and 0x220 for the high half. Writes to one half leave the other half unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_in | input | 64 | Interrupt lines; bit 32*h+i is line i of half h |
| irq_out | output | 1 | Combined interrupt output |

## Verification
Each input passes through a capture flop, so a level change shows up in bank status one clock edge after it is driven. A selected edge needs a second flop for comparison before the latch is set, so it appears after two edges. The output adds one more register after the status. Register writes take effect at the edge that ends the strobe and are read back combinationally after that edge. The bench drives everything on the falling edge and waits at least three edges after each input change before it samples. The one exception is the output timing check, which samples one cycle and then two cycles after an enable write, to pin down the single-cycle lag of the output.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int HALVES = 2;

  localparam logic [ADDR_W-1:0] BANK_BASE    = 12'h000;
  localparam logic [ADDR_W-1:0] BANK_HI_STEP = 12'h018;
  localparam logic [ADDR_W-1:0] EDGE_BASE    = 12'h200;
  localparam logic [ADDR_W-1:0] EDGE_HI_STEP = 12'h020;

  // bank group offsets
  localparam logic [ADDR_W-1:0] BK_STATUS = 12'h000;
  localparam logic [ADDR_W-1:0] BK_RAW    = 12'h004;
  localparam logic [ADDR_W-1:0] BK_EN_SET = 12'h008;
  localparam logic [ADDR_W-1:0] BK_EN_CLR = 12'h00c;
  localparam logic [ADDR_W-1:0] BK_SF_SET = 12'h010;
  localparam logic [ADDR_W-1:0] BK_SF_CLR = 12'h014;

  // edge group offsets
  localparam logic [ADDR_W-1:0] ED_STATUS = 12'h000;
  localparam logic [ADDR_W-1:0] ED_RAW    = 12'h004;
  localparam logic [ADDR_W-1:0] ED_RISE   = 12'h008;
  localparam logic [ADDR_W-1:0] ED_FALL   = 12'h00c;
  localparam logic [ADDR_W-1:0] ED_RI_SET = 12'h010;
  localparam logic [ADDR_W-1:0] ED_RI_CLR = 12'h014;
  localparam logic [ADDR_W-1:0] ED_FA_SET = 12'h018;
  localparam logic [ADDR_W-1:0] ED_FA_CLR = 12'h01c;

  // trigger selection as {rise, fall}
  typedef enum logic [1:0] {
    TRIG_LVL_HI = 2'b00,
    TRIG_FALL   = 2'b01,
    TRIG_RISE   = 2'b10,
    TRIG_LVL_LO = 2'b11
  } trig_t;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic sf_set;
    logic sf_clr;
    logic ri_wr;
    logic ri_set;
    logic ri_clr;
    logic fa_wr;
    logic fa_set;
    logic fa_clr;
    logic ack;
  } half_wr_t;

endpackage

// File: rtl/ictl_regif.sv
module ictl_regif
  import ictl_pkg::*;
(
  input  logic                          reg_wr,
  input  logic [ADDR_W-1:0]             reg_addr,
  output half_wr_t [HALVES-1:0]         wr_strb
);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam logic [ADDR_W-1:0] BB = BANK_BASE + ADDR_W'(h) * BANK_HI_STEP;
    localparam logic [ADDR_W-1:0] EB = EDGE_BASE + ADDR_W'(h) * EDGE_HI_STEP;
    half_wr_t s;

    always_comb begin
      s        = '0;
      s.en_set = reg_wr && (reg_addr == BB + BK_EN_SET);
      s.en_clr = reg_wr && (reg_addr == BB + BK_EN_CLR);
      s.sf_set = reg_wr && (reg_addr == BB + BK_SF_SET);
      s.sf_clr = reg_wr && (reg_addr == BB + BK_SF_CLR);
      s.ack    = reg_wr && (reg_addr == EB + ED_RAW);
      s.ri_wr  = reg_wr && (reg_addr == EB + ED_RISE);
      s.fa_wr  = reg_wr && (reg_addr == EB + ED_FALL);
      s.ri_set = reg_wr && (reg_addr == EB + ED_RI_SET);
      s.ri_clr = reg_wr && (reg_addr == EB + ED_RI_CLR);
      s.fa_set = reg_wr && (reg_addr == EB + ED_FA_SET);
      s.fa_clr = reg_wr && (reg_addr == EB + ED_FA_CLR);
    end

    assign wr_strb[h] = s;
  end

endmodule

// File: rtl/ictl_edge.sv
module ictl_edge
  import ictl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  lines,
  input  half_wr_t      strb,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  cond,
  output logic [W-1:0]  latch,
  output logic [W-1:0]  edge_mode,
  output logic [W-1:0]  rise_cfg,
  output logic [W-1:0]  fall_cfg
);

  logic [W-1:0] in_q, in_d;
  logic [W-1:0] rise_q, rise_n, fall_q, fall_n;
  logic [W-1:0] lat_q, lat_n;
  logic [W-1:0] det;
  logic         rise_ce, fall_ce;

  // per-line trigger decode
  for (genvar i = 0; i < W; i++) begin : g_line
    trig_t mode;
    assign mode = trig_t'({rise_q[i], fall_q[i]});
    always_comb begin
      det[i]       = 1'b0;
      edge_mode[i] = 1'b0;
      cond[i]      = 1'b0;
      case (mode)
        TRIG_RISE: begin
          edge_mode[i] = 1'b1;
          det[i]       = in_q[i] & ~in_d[i];
          cond[i]      = lat_q[i];
        end
        TRIG_FALL: begin
          edge_mode[i] = 1'b1;
          det[i]       = ~in_q[i] & in_d[i];
          cond[i]      = lat_q[i];
        end
        TRIG_LVL_LO: cond[i] = ~in_q[i];
        default:     cond[i] = in_q[i];
      endcase
    end
  end

  always_comb begin
    rise_ce = strb.ri_wr | strb.ri_set | strb.ri_clr;
    fall_ce = strb.fa_wr | strb.fa_set | strb.fa_clr;

    rise_n = rise_q;
    if (strb.ri_wr)  rise_n = wdata;
    if (strb.ri_set) rise_n = rise_q | wdata;
    if (strb.ri_clr) rise_n = rise_q & ~wdata;

    fall_n = fall_q;
    if (strb.fa_wr)  fall_n = wdata;
    if (strb.fa_set) fall_n = fall_q | wdata;
    if (strb.fa_clr) fall_n = fall_q & ~wdata;

    // a newly detected edge wins over an acknowledge in the same cycle
    lat_n = lat_q;
    if (strb.ack) lat_n = lat_q & ~wdata;
    lat_n = lat_n | det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= '0;
      in_d <= '0;
    end else begin
      in_q <= lines;
      in_d <= in_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
    end else if (rise_ce) begin
      rise_q <= rise_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= '0;
    end else if (fall_ce) begin
      fall_q <= fall_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else begin
      lat_q <= lat_n;
    end
  end

  assign latch    = lat_q;
  assign rise_cfg = rise_q;
  assign fall_cfg = fall_q;

endmodule

// File: rtl/ictl_bank.sv
module ictl_bank
  import ictl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  half_wr_t      strb,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  cond,
  output logic [W-1:0]  enable,
  output logic [W-1:0]  force_q,
  output logic [W-1:0]  raw,
  output logic [W-1:0]  status
);

  logic [W-1:0] en_q, en_n, sf_q, sf_n;
  logic         en_ce, sf_ce;

  always_comb begin
    en_ce = strb.en_set | strb.en_clr;
    sf_ce = strb.sf_set | strb.sf_clr;
    en_n  = en_q;
    if (strb.en_set) en_n = en_q | wdata;
    if (strb.en_clr) en_n = en_q & ~wdata;
    sf_n  = sf_q;
    if (strb.sf_set) sf_n = sf_q | wdata;
    if (strb.sf_clr) sf_n = sf_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q <= '0;
    end else if (sf_ce) begin
      sf_q <= sf_n;
    end
  end

  assign raw     = cond | sf_q;
  assign status  = raw & en_q;
  assign enable  = en_q;
  assign force_q = sf_q;

endmodule

// File: rtl/ictl_dual_bank.sv
module ictl_dual_bank
  import ictl_pkg::*;
#(
  parameter int BANK_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [11:0]              reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [2*BANK_W-1:0]      irq_in,
  output logic                     irq_out
);

  localparam int NUM_IN = HALVES * BANK_W;

  half_wr_t [HALVES-1:0] wr_strb;
  logic [NUM_IN-1:0]     en_all, soft_all, raw_all, status_all;
  logic [NUM_IN-1:0]     cond_all, lat_all, emode_all, rise_all, fall_all;
  logic [DATA_W-1:0]     rd_part [HALVES];
  logic                  irq_q, irq_n;

  ictl_regif u_regif (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wr_strb  (wr_strb)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam logic [ADDR_W-1:0] BB = BANK_BASE + ADDR_W'(h) * BANK_HI_STEP;
    localparam logic [ADDR_W-1:0] EB = EDGE_BASE + ADDR_W'(h) * EDGE_HI_STEP;

    ictl_edge #(.W(BANK_W)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .lines     (irq_in[h*BANK_W +: BANK_W]),
      .strb      (wr_strb[h]),
      .wdata     (reg_wdata[BANK_W-1:0]),
      .cond      (cond_all[h*BANK_W +: BANK_W]),
      .latch     (lat_all[h*BANK_W +: BANK_W]),
      .edge_mode (emode_all[h*BANK_W +: BANK_W]),
      .rise_cfg  (rise_all[h*BANK_W +: BANK_W]),
      .fall_cfg  (fall_all[h*BANK_W +: BANK_W])
    );

    ictl_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .strb    (wr_strb[h]),
      .wdata   (reg_wdata[BANK_W-1:0]),
      .cond    (cond_all[h*BANK_W +: BANK_W]),
      .enable  (en_all[h*BANK_W +: BANK_W]),
      .force_q (soft_all[h*BANK_W +: BANK_W]),
      .raw     (raw_all[h*BANK_W +: BANK_W]),
      .status  (status_all[h*BANK_W +: BANK_W])
    );

    logic [BANK_W-1:0] sel;
    always_comb begin
      case (reg_addr)
        BB + BK_STATUS: sel = status_all[h*BANK_W +: BANK_W];
        BB + BK_RAW:    sel = raw_all[h*BANK_W +: BANK_W];
        BB + BK_EN_SET,
        BB + BK_EN_CLR: sel = en_all[h*BANK_W +: BANK_W];
        BB + BK_SF_SET,
        BB + BK_SF_CLR: sel = soft_all[h*BANK_W +: BANK_W];
        EB + ED_STATUS: sel = lat_all[h*BANK_W +: BANK_W] & emode_all[h*BANK_W +: BANK_W];
        EB + ED_RAW:    sel = lat_all[h*BANK_W +: BANK_W];
        EB + ED_RISE,
        EB + ED_RI_SET,
        EB + ED_RI_CLR: sel = rise_all[h*BANK_W +: BANK_W];
        EB + ED_FALL,
        EB + ED_FA_SET,
        EB + ED_FA_CLR: sel = fall_all[h*BANK_W +: BANK_W];
        default:        sel = '0;
      endcase
      rd_part[h]             = '0;
      rd_part[h][BANK_W-1:0] = sel;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int h = 0; h < HALVES; h++) begin
      reg_rdata = reg_rdata | rd_part[h];
    end
    irq_n = |status_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_n;
    end
  end

  assign irq_out = irq_q;

endmodule

// File: rtl/ictl_checker.sv
module ictl_checker
  import ictl_pkg::*;
#(
  parameter int W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input half_wr_t [HALVES-1:0]  strb,
  input logic [31:0]            wdata,
  input logic [HALVES*W-1:0]    en_all,
  input logic [HALVES*W-1:0]    soft_all,
  input logic [HALVES*W-1:0]    lat_all,
  input logic [HALVES*W-1:0]    emode_all,
  input logic                   irq_out
);

  for (genvar h = 0; h < HALVES; h++) begin : g_chk
    // R2: bits written to enable-clear are gone afterwards
    a_r2_en_clear: assert property (@(posedge clk) disable iff (!rst_n)
      strb[h].en_clr |=> ((en_all[h*W +: W] & $past(wdata[W-1:0])) == '0));

    // R3: bits written to force-set are present afterwards
    a_r3_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
      strb[h].sf_set |=> ((soft_all[h*W +: W] & $past(wdata[W-1:0])) == $past(wdata[W-1:0])));
  end

  // R6: a latch only turns on for a line that was in an edge mode
  a_r6_latch_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat_all & ~$past(lat_all) & ~$past(emode_all)) == '0));

  // R9: no enables means no output in the next cycle
  a_r9_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |=> !irq_out);

endmodule

bind ictl_dual_bank ictl_checker #(.W(BANK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .strb      (wr_strb),
  .wdata     (reg_wdata),
  .en_all    (en_all),
  .soft_all  (soft_all),
  .lat_all   (lat_all),
  .emode_all (emode_all),
  .irq_out   (irq_out)
);

// File: tb/test_ictl_dual_bank.sv
module test_ictl_dual_bank;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [63:0] irq_in;
  logic        irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  ictl_dual_bank i_ictl_dual_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_in    (irq_in),
    .irq_out   (irq_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [11:0] bka(int h, int off);
    return 12'(h * 'h18 + off);
  endfunction

  function automatic logic [11:0] eda(int h, int off);
    return 12'('h200 + h * 'h20 + off);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bitpos(int i);
    return (i == 0) ? 0 : ((i == 1) ? 13 : 31);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m, exp;
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    irq_in    = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state of every readable register and the output
    for (int h = 0; h < 2; h++) begin
      for (int off = 0; off < 'h18; off += 4) begin
        rd(bka(h, off), d);
        chk("R1 bank reg after reset", d, 32'h0);
      end
      for (int off = 0; off < 'h20; off += 4) begin
        rd(eda(h, off), d);
        chk("R1 edge reg after reset", d, 32'h0);
      end
    end
    chk("R1 irq_out after reset", {31'h0, irq_out}, 32'h0);

    // R1: default level-high mode passes an input to raw status
    irq_in[3] = 1'b1;
    idle(3);
    rd(bka(0, 'h04), d);
    chk("R1 default level high raw", d, 32'h8);
    irq_in[3] = 1'b0;
    idle(3);

    // R2, R10: enable aliases on both halves
    for (int h = 0; h < 2; h++) begin
      wr(bka(h, 'h08), 32'hF0F0_00FF);
      wr(bka(h, 'h0c), 32'h00F0_000F);
      rd(bka(h, 'h08), d);
      chk("R2 enable via set alias", d, 32'hF000_00F0);
      rd(bka(h, 'h0c), d);
      chk("R2 enable via clear alias", d, 32'hF000_00F0);
      rd(bka(1 - h, 'h08), d);
      chk("R10 other half enable", d, (h == 0) ? 32'h0 : 32'hF000_00F0);
    end
    wr(bka(0, 'h0c), 32'hFFFF_FFFF);
    wr(bka(1, 'h0c), 32'hFFFF_FFFF);

    // R3: force aliases
    for (int h = 0; h < 2; h++) begin
      wr(bka(h, 'h10), 32'h1234_5678);
      wr(bka(h, 'h14), 32'h0204_0608);
      rd(bka(h, 'h10), d);
      chk("R3 force via set alias", d, 32'h1030_5070);
      rd(bka(h, 'h14), d);
      chk("R3 force via clear alias", d, 32'h1030_5070);
      wr(bka(h, 'h14), 32'hFFFF_FFFF);
      rd(bka(h, 'h10), d);
      chk("R3 force cleared", d, 32'h0);
    end

    // R5: configuration direct and alias access
    for (int h = 0; h < 2; h++) begin
      wr(eda(h, 'h08), 32'hAAAA_0000);
      wr(eda(h, 'h10), 32'h0000_000F);
      wr(eda(h, 'h14), 32'h0A00_0003);
      rd(eda(h, 'h08), d);
      chk("R5 rise config", d, 32'hA0AA_000C);
      rd(eda(h, 'h14), d);
      chk("R5 rise via clear alias", d, 32'hA0AA_000C);
      wr(eda(h, 'h0c), 32'h5555_0000);
      wr(eda(h, 'h18), 32'h0000_0F00);
      wr(eda(h, 'h1c), 32'h0050_0300);
      rd(eda(h, 'h0c), d);
      chk("R5 fall config", d, 32'h5505_0C00);
      rd(eda(h, 'h18), d);
      chk("R5 fall via set alias", d, 32'h5505_0C00);
      wr(eda(h, 'h08), 32'h0);
      wr(eda(h, 'h0c), 32'h0);
    end

    // R8, R9: force with and without enable, and output lag
    wr(bka(0, 'h10), 32'h0000_0100);
    rd(bka(0, 'h04), d);
    chk("R8 raw shows force", d, 32'h100);
    rd(bka(0, 'h00), d);
    chk("R8 status masked by enable", d, 32'h0);
    chk("R9 output low without enable", {31'h0, irq_out}, 32'h0);
    wr(bka(0, 'h08), 32'h0000_0100);
    chk("R9 output one cycle late", {31'h0, irq_out}, 32'h0);
    idle(1);
    chk("R9 output follows status", {31'h0, irq_out}, 32'h1);
    wr(bka(0, 'h14), 32'h0000_0100);
    wr(bka(0, 'h0c), 32'hFFFF_FFFF);
    idle(1);
    chk("R9 output drops", {31'h0, irq_out}, 32'h0);

    // R4, R6, R7, R8, R10: sweep of every trigger mode over several lines
    for (int h = 0; h < 2; h++) begin
      for (int mo = 0; mo < 4; mo++) begin
        for (int bi = 0; bi < 3; bi++) begin
          int b;
          b = bitpos(bi);
          m = 32'h1 << b;
          irq_in[h*32+b] = 1'b0;
          idle(3);
          wr(eda(h, 'h14), 32'hFFFF_FFFF);
          wr(eda(h, 'h1c), 32'hFFFF_FFFF);
          if (mo[1]) wr(eda(h, 'h10), m);
          if (mo[0]) wr(eda(h, 'h18), m);
          wr(eda(h, 'h04), 32'hFFFF_FFFF);
          wr(bka(h, 'h0c), 32'hFFFF_FFFF);
          wr(bka(h, 'h08), m);
          idle(1);
          exp = (mo == 3) ? m : 32'h0;
          rd(bka(h, 'h00), d);
          chk("R4 R8 status with input low", d, exp);
          chk("R9 output with input low", {31'h0, irq_out}, {31'h0, exp != 0});

          irq_in[h*32+b] = 1'b1;
          idle(3);
          exp = (mo == 0 || mo == 2) ? m : 32'h0;
          rd(bka(h, 'h00), d);
          chk("R4 R8 status after input rises", d, exp);
          exp = (mo == 2) ? m : 32'h0;
          rd(eda(h, 'h04), d);
          chk("R6 latch after rise", d, exp);
          rd(eda(h, 'h00), d);
          chk("R6 edge status after rise", d, exp);
          rd(bka(1 - h, 'h00), d);
          chk("R10 other half quiet", d, 32'h0);

          wr(eda(h, 'h04), m);
          idle(1);
          exp = (mo == 0) ? m : 32'h0;
          rd(bka(h, 'h00), d);
          chk("R7 status after acknowledge", d, exp);
          rd(eda(h, 'h04), d);
          chk("R7 latch cleared", d, 32'h0);

          irq_in[h*32+b] = 1'b0;
          idle(3);
          exp = (mo == 1 || mo == 3) ? m : 32'h0;
          rd(bka(h, 'h00), d);
          chk("R4 R8 status after input falls", d, exp);
          exp = (mo == 1) ? m : 32'h0;
          rd(eda(h, 'h04), d);
          chk("R6 latch after fall", d, exp);

          // R7: acknowledging another bit keeps this latch
          wr(eda(h, 'h04), ~m);
          rd(eda(h, 'h04), d);
          chk("R7 ack of other bits", d, exp);
          wr(eda(h, 'h04), 32'hFFFF_FFFF);
        end
      end
      wr(bka(h, 'h0c), 32'hFFFF_FFFF);
      wr(eda(h, 'h14), 32'hFFFF_FFFF);
      wr(eda(h, 'h1c), 32'hFFFF_FFFF);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule